// File: doc/BRIEF.md
# Format Table Interleave Mapper

This block sits behind the sector buffer that a host fills before it formats a track. The host streams buffer bytes one at a time through a write port. Every physical slot on the track takes one pair of bytes. The first byte of the pair is a good/bad marker and the second is the logical sector number to be recorded in that slot. A separate sector count register tells the block how many pairs are meaningful. The rest of the buffer is filler, but it must still be written before a format may begin.

When the last buffer byte arrives and the count is legal, the block commits the table and pulses a format-start output. It then answers lookups. Given a logical sector number, it returns one cycle later the physical slot that holds it and whether that slot is marked bad. A slot marked bad is what later reads or writes consult to raise their bad-block status. All slots are searched at once. Duplicated numbers resolve to the lowest slot, and absent numbers are reported as not found. An illegal count or a malformed marker byte raises an error output.

Top module: `fmt_ilv_map`

## Requirements
- R1: After reset `fmt_start`, `cnt_err`, `tbl_err` and `lk_vld` are 0, and any lookup answers not-found until a table has been committed.
- R2: Buffer byte 2k is the marker of physical slot k and byte 2k+1 is its logical number. A lookup of that number returns slot k.
- R3: A marker of 0x00 makes the slot good (`lk_bad`=0), and a marker of 0x80 makes it bad (`lk_bad`=1).
- R4: A marker other than 0x00 or 0x80 marks its slot bad. If that slot lies below the committed count, `tbl_err` is 1 from the cycle after the final buffer byte.
- R5: `fmt_start` is a single-cycle pulse. It is high in the cycle after the BUF_BYTES-th byte is accepted, and only when the count register holds 1..MAX_SECT at that moment. It is never high earlier in the fill.
- R6: A count of 0 or above MAX_SECT when the buffer fills gives no `fmt_start` and sets `cnt_err`. The error stays set until the next `buf_start`, and lookups answer not-found.
- R7: Only slots below the count sampled at the final byte take part in lookups. Writing the count register after the commit does not change the committed table.
- R8: A lookup of a number held by no active slot returns `lk_miss`=1, `lk_slot`=0 and `lk_bad`=0.
- R9: When several active slots hold the same number, the lookup returns the lowest such slot.
- R10: `lk_vld` is 1 exactly in the cycle after a cycle with `lk_req`=1 and carries the result for that request's key. It is 0 otherwise.
- R11: Byte writes after the buffer is full are ignored until `buf_start`. `buf_start` restarts the fill at byte 0, deactivates the table and clears both error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_start | input | 1 | Begin a new buffer fill |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_data | input | 8 | Buffer byte |
| cnt_we | input | 1 | Sector count register write strobe |
| cnt_wdata | input | 8 | Sector count value |
| lk_req | input | 1 | Lookup request |
| lk_key | input | LSN_W | Logical sector number to look up |
| fmt_start | output | 1 | One-cycle format start pulse |
| cnt_err | output | 1 | Illegal count seen at buffer fill |
| tbl_err | output | 1 | Malformed marker among the active slots |
| lk_vld | output | 1 | Lookup response valid |
| lk_slot | output | SLOT_W | Physical slot of the found sector |
| lk_bad | output | 1 | Found slot is marked bad |
| lk_miss | output | 1 | Number not present in the active table |

## Verification
The mapping is first driven with a regular 4:1 interleave over 32 sectors. Every logical number is looked up against a closed-form slot formula, which separates a correct pair decode from a swapped or shifted byte pointer. Directed tables then add bad and malformed markers, duplicates, counts of 0 and 33, and writes after the buffer is full. These tell apart the priority order, the count masking and the commit timing. Random tables with short counts and keys drawn from a range wider than the table mix hits, misses and repeats, and are compared against a bench model of the buffer.

// File: rtl/fmt_ilv_pkg.sv
package fmt_ilv_pkg;

   localparam logic [7:0] MARK_GOOD = 8'h00;
   localparam logic [7:0] MARK_BAD  = 8'h80;

   // position of a byte inside its slot pair
   typedef enum logic {
      ROLE_MARK = 1'b0,
      ROLE_LSN  = 1'b1
   } byte_role_e;

   function automatic logic mark_is_bad(input logic [7:0] m);
      return m != MARK_GOOD;
   endfunction

   function automatic logic mark_is_junk(input logic [7:0] m);
      return (m != MARK_GOOD) && (m != MARK_BAD);
   endfunction

endpackage

// File: rtl/fmt_ilv_fill.sv
module fmt_ilv_fill
   import fmt_ilv_pkg::*;
#(
   parameter int BUF_BYTES = 256,
   parameter int MAX_SECT  = 32,
   localparam int PTR_W    = $clog2(BUF_BYTES),
   localparam int SLOT_W   = $clog2(MAX_SECT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_start,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic              ent_we,
   output logic [SLOT_W-1:0] ent_idx,
   output byte_role_e        ent_role,
   output logic [7:0]        ent_byte,
   output logic              fill_done
);

   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(BUF_BYTES - 1);

   logic [PTR_W-1:0] ptr;
   logic             full;
   logic             accept;
   logic             in_tbl;

   assign accept   = wr_en && !full && !buf_start;
   assign in_tbl   = int'(ptr[PTR_W-1:1]) < MAX_SECT;
   assign ent_we   = accept && in_tbl;
   assign ent_idx  = SLOT_W'(ptr[PTR_W-1:1]);
   assign ent_role = byte_role_e'(ptr[0]);
   assign ent_byte = wr_data;
   assign fill_done = accept && (ptr == LAST_PTR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr  <= '0;
         full <= 1'b0;
      end else if (buf_start) begin
         ptr  <= '0;
         full <= 1'b0;
      end else if (accept) begin
         if (ptr == LAST_PTR) full <= 1'b1;
         else                 ptr  <= ptr + 1'b1;
      end
   end

   // R11: once full, the pointer is frozen until a new fill starts
   assert_full_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !buf_start) |=> (full && $stable(ptr)));

   // R5: completion can only come from the final buffer position
   assert_done_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> full);

endmodule

// File: rtl/fmt_ilv_table.sv
module fmt_ilv_table
   import fmt_ilv_pkg::*;
#(
   parameter int MAX_SECT = 32,
   parameter int LSN_W    = 8,
   localparam int SLOT_W  = $clog2(MAX_SECT)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             ent_we,
   input  logic [SLOT_W-1:0]                ent_idx,
   input  byte_role_e                       ent_role,
   input  logic [7:0]                       ent_byte,
   output logic [MAX_SECT-1:0][LSN_W-1:0]   lsn_v,
   output logic [MAX_SECT-1:0]              bad_v,
   output logic [MAX_SECT-1:0]              junk_v
);

   for (genvar g = 0; g < MAX_SECT; g++) begin : g_slot
      logic sel;
      assign sel = ent_we && (ent_idx == SLOT_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            lsn_v[g]  <= '0;
            bad_v[g]  <= 1'b0;
            junk_v[g] <= 1'b0;
         end else if (sel) begin
            if (ent_role == ROLE_MARK) begin
               bad_v[g]  <= mark_is_bad(ent_byte);
               junk_v[g] <= mark_is_junk(ent_byte);
            end else begin
               lsn_v[g]  <= ent_byte[LSN_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/fmt_ilv_ctrl.sv
module fmt_ilv_ctrl #(
   parameter int MAX_SECT = 32,
   parameter int CNT_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                buf_start,
   input  logic                fill_done,
   input  logic                cnt_we,
   input  logic [CNT_W-1:0]    cnt_wdata,
   input  logic [MAX_SECT-1:0] junk_v,
   output logic [MAX_SECT-1:0] act_mask,
   output logic                fmt_start,
   output logic                cnt_err,
   output logic                tbl_err
);

   logic [CNT_W-1:0]    cnt_q;
   logic                cnt_ok;
   logic [MAX_SECT-1:0] new_mask;

   function automatic logic [MAX_SECT-1:0] mask_of(input logic [CNT_W-1:0] c);
      logic [MAX_SECT-1:0] m;
      for (int i = 0; i < MAX_SECT; i++) m[i] = int'(c) > i;
      return m;
   endfunction

   assign cnt_ok   = (cnt_q != '0) && (int'(cnt_q) <= MAX_SECT);
   assign new_mask = mask_of(cnt_q);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (cnt_we)  cnt_q <= cnt_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_mask  <= '0;
         fmt_start <= 1'b0;
         cnt_err   <= 1'b0;
         tbl_err   <= 1'b0;
      end else begin
         fmt_start <= 1'b0;
         if (buf_start) begin
            act_mask <= '0;
            cnt_err  <= 1'b0;
            tbl_err  <= 1'b0;
         end else if (fill_done) begin
            if (cnt_ok) begin
               act_mask  <= new_mask;
               fmt_start <= 1'b1;
               tbl_err   <= |(junk_v & new_mask);
            end else begin
               cnt_err   <= 1'b1;
            end
         end
      end
   end

   assert_pulse_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_start |=> !fmt_start);

   assert_start_vs_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_start |-> !cnt_err);

   assert_cnt_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_err && !buf_start) |=> cnt_err);

   // R7: committed table only changes at a fill completion or a restart
   assert_mask_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_start && !fill_done) |=> $stable(act_mask));

endmodule

// File: rtl/fmt_ilv_lookup.sv
module fmt_ilv_lookup #(
   parameter int MAX_SECT = 32,
   parameter int LSN_W    = 8,
   localparam int SLOT_W  = $clog2(MAX_SECT)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [MAX_SECT-1:0]            act_mask,
   input  logic [MAX_SECT-1:0][LSN_W-1:0] lsn_v,
   input  logic [MAX_SECT-1:0]            bad_v,
   input  logic                           lk_req,
   input  logic [LSN_W-1:0]               lk_key,
   output logic                           lk_vld,
   output logic [SLOT_W-1:0]              lk_slot,
   output logic                           lk_bad,
   output logic                           lk_miss
);

   logic [MAX_SECT-1:0] hit_v;
   logic [SLOT_W-1:0]   sel;
   logic                found;

   for (genvar g = 0; g < MAX_SECT; g++) begin : g_cmp
      assign hit_v[g] = act_mask[g] && (lsn_v[g] == lk_key);
   end

   // lowest slot wins: scan downward so the last assignment is the lowest hit
   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int i = MAX_SECT - 1; i >= 0; i--) begin
         if (hit_v[i]) begin
            sel   = SLOT_W'(i);
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_vld  <= 1'b0;
         lk_slot <= '0;
         lk_bad  <= 1'b0;
         lk_miss <= 1'b0;
      end else begin
         lk_vld <= lk_req;
         if (lk_req) begin
            lk_slot <= found ? sel : '0;
            lk_bad  <= found && bad_v[sel];
            lk_miss <= !found;
         end
      end
   end

   assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_vld);

   assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !lk_vld);

   assert_miss_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vld && lk_miss) |-> (lk_slot == '0 && !lk_bad));

   assert_idle_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && act_mask == '0) |=> lk_miss);

endmodule

// File: rtl/fmt_ilv_map.sv
module fmt_ilv_map
   import fmt_ilv_pkg::*;
#(
   parameter int BUF_BYTES = 256,
   parameter int MAX_SECT  = 32,
   parameter int LSN_W     = 8,
   localparam int SLOT_W   = $clog2(MAX_SECT),
   localparam int CNT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_start,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              cnt_we,
   input  logic [7:0]        cnt_wdata,
   input  logic              lk_req,
   input  logic [LSN_W-1:0]  lk_key,
   output logic              fmt_start,
   output logic              cnt_err,
   output logic              tbl_err,
   output logic              lk_vld,
   output logic [SLOT_W-1:0] lk_slot,
   output logic              lk_bad,
   output logic              lk_miss
);

   if (MAX_SECT < 2 || MAX_SECT > 255) begin : g_chk_sect
      $error("MAX_SECT must lie in 2..255");
   end
   if (BUF_BYTES < 2 * MAX_SECT) begin : g_chk_buf
      $error("BUF_BYTES must hold one byte pair per slot");
   end
   if (LSN_W < 1 || LSN_W > 8) begin : g_chk_lsn
      $error("LSN_W must lie in 1..8");
   end

   logic                           ent_we;
   logic [SLOT_W-1:0]              ent_idx;
   byte_role_e                     ent_role;
   logic [7:0]                     ent_byte;
   logic                           fill_done;
   logic [MAX_SECT-1:0][LSN_W-1:0] lsn_v;
   logic [MAX_SECT-1:0]            bad_v;
   logic [MAX_SECT-1:0]            junk_v;
   logic [MAX_SECT-1:0]            act_mask;

   fmt_ilv_fill #(.BUF_BYTES(BUF_BYTES), .MAX_SECT(MAX_SECT)) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_start (buf_start),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .ent_we    (ent_we),
      .ent_idx   (ent_idx),
      .ent_role  (ent_role),
      .ent_byte  (ent_byte),
      .fill_done (fill_done)
   );

   fmt_ilv_table #(.MAX_SECT(MAX_SECT), .LSN_W(LSN_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (buf_start),
      .ent_we   (ent_we),
      .ent_idx  (ent_idx),
      .ent_role (ent_role),
      .ent_byte (ent_byte),
      .lsn_v    (lsn_v),
      .bad_v    (bad_v),
      .junk_v   (junk_v)
   );

   fmt_ilv_ctrl #(.MAX_SECT(MAX_SECT), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_start (buf_start),
      .fill_done (fill_done),
      .cnt_we    (cnt_we),
      .cnt_wdata (cnt_wdata),
      .junk_v    (junk_v),
      .act_mask  (act_mask),
      .fmt_start (fmt_start),
      .cnt_err   (cnt_err),
      .tbl_err   (tbl_err)
   );

   fmt_ilv_lookup #(.MAX_SECT(MAX_SECT), .LSN_W(LSN_W)) u_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_mask (act_mask),
      .lsn_v    (lsn_v),
      .bad_v    (bad_v),
      .lk_req   (lk_req),
      .lk_key   (lk_key),
      .lk_vld   (lk_vld),
      .lk_slot  (lk_slot),
      .lk_bad   (lk_bad),
      .lk_miss  (lk_miss)
   );

endmodule

// File: tb/fmt_ilv_map_bench.sv
`timescale 1ns/1ps
module fmt_ilv_map_bench;

   localparam int BUF  = 256;
   localparam int MAXS = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       buf_start = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       cnt_we = 1'b0;
   logic [7:0] cnt_wdata = '0;
   logic       lk_req = 1'b0;
   logic [7:0] lk_key = '0;
   logic       fmt_start, cnt_err, tbl_err, lk_vld, lk_bad, lk_miss;
   logic [4:0] lk_slot;

   int  nchk = 0;
   int  nfail = 0;
   bit  finished = 0;
   int  mcnt = 0;
   logic [7:0] bmem [BUF];

   always #2.5 clk = ~clk;

   fmt_ilv_map u_fmt_ilv_map (
      .clk(clk), .rst_n(rst_n), .buf_start(buf_start), .wr_en(wr_en),
      .wr_data(wr_data), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .lk_req(lk_req), .lk_key(lk_key), .fmt_start(fmt_start),
      .cnt_err(cnt_err), .tbl_err(tbl_err), .lk_vld(lk_vld),
      .lk_slot(lk_slot), .lk_bad(lk_bad), .lk_miss(lk_miss)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit cnt_legal(input int c);
      return c >= 1 && c <= MAXS;
   endfunction

   function automatic int model_tbl_err(input int c);
      for (int i = 0; i < c; i++)
         if (bmem[2*i] != 8'h00 && bmem[2*i] != 8'h80) return 1;
      return 0;
   endfunction

   // returns slot or -1 when absent; active only when mcnt > 0
   function automatic int model_slot(input logic [7:0] key);
      for (int i = 0; i < mcnt; i++)
         if (bmem[2*i+1] == key) return i;
      return -1;
   endfunction

   task automatic load_cnt(input int v);
      cnt_we = 1'b1; cnt_wdata = 8'(v);
      @(negedge clk);
      cnt_we = 1'b0;
   endtask

   task automatic push_buf(input int c, input string tag);
      bit ok;
      ok = cnt_legal(c);
      buf_start = 1'b1;
      @(negedge clk);
      buf_start = 1'b0;
      for (int i = 0; i < BUF; i++) begin
         wr_en = 1'b1; wr_data = bmem[i];
         @(negedge clk);
         if (i == BUF - 2) chk({tag, " R5 no early start"}, int'(fmt_start), 0);
      end
      wr_en = 1'b0;
      chk({tag, " R5 start pulse"}, int'(fmt_start), int'(ok));
      chk({tag, " R6 count error"}, int'(cnt_err), int'(!ok));
      chk({tag, " R4 table error"}, int'(tbl_err), ok ? model_tbl_err(c) : 0);
      mcnt = ok ? c : 0;
      @(negedge clk);
      chk({tag, " R5 pulse width"}, int'(fmt_start), 0);
   endtask

   task automatic look(input logic [7:0] key, input string tag);
      int s;
      s = model_slot(key);
      lk_req = 1'b1; lk_key = key;
      @(negedge clk);
      lk_req = 1'b0;
      chk({tag, " R10 valid"}, int'(lk_vld), 1);
      chk({tag, " R8 miss"}, int'(lk_miss), int'(s < 0));
      chk({tag, " R2/R9 slot"}, int'(lk_slot), s < 0 ? 0 : s);
      chk({tag, " R3 bad"}, int'(lk_bad), s < 0 ? 0 : int'(bmem[2*s] != 8'h00));
   endtask

   task automatic fill_interleave();
      for (int i = 0; i < MAXS; i++) begin
         bmem[2*i]   = 8'h00;
         bmem[2*i+1] = 8'((i % 4) * 8 + i / 4);
      end
      for (int i = 2 * MAXS; i < BUF; i++) bmem[i] = 8'hA5;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 fmt_start", int'(fmt_start), 0);
      chk("R1 cnt_err", int'(cnt_err), 0);
      chk("R1 tbl_err", int'(tbl_err), 0);
      chk("R1 lk_vld", int'(lk_vld), 0);
      lk_req = 1'b1; lk_key = 8'h00;
      @(negedge clk);
      lk_req = 1'b0;
      chk("R1 idle lookup miss", int'(lk_miss), 1);

      // R2 regular 4:1 interleave, slot from closed form
      fill_interleave();
      load_cnt(32);
      push_buf(32, "ilv");
      for (int l = 0; l < MAXS; l++) begin
         lk_req = 1'b1; lk_key = 8'(l);
         @(negedge clk);
         lk_req = 1'b0;
         chk("R2 interleave slot", int'(lk_slot), (l % 8) * 4 + l / 8);
         chk("R2 interleave hit", int'(lk_miss), 0);
      end
      @(negedge clk);
      chk("R10 valid drops", int'(lk_vld), 0);

      // R3/R4 bad and malformed markers
      bmem[10] = 8'h80;
      bmem[18] = 8'h33;
      push_buf(32, "marks");
      chk("R4 tbl_err set", int'(tbl_err), 1);
      look(bmem[11], "R3 marked bad");
      look(bmem[19], "R4 junk is bad");
      look(bmem[1], "R3 good slot");

      // R7 junk beyond count ignored, slots beyond count absent
      load_cnt(8);
      push_buf(8, "short");
      chk("R7 tbl_err beyond count", int'(tbl_err), 0);
      look(8'd18, "R7 slot beyond count");
      look(bmem[11], "R7 slot in count");

      // R7 count written after commit has no effect
      load_cnt(1);
      look(bmem[11], "R7 late count write");

      // R11 writes after full ignored
      for (int i = 0; i < 10; i++) begin
         wr_en = 1'b1; wr_data = 8'hFF;
         @(negedge clk);
      end
      wr_en = 1'b0;
      chk("R11 no start on extra writes", int'(fmt_start), 0);
      look(bmem[3], "R11 after overwrite");
      look(8'hFF, "R11 overwrite value absent");

      // R9 duplicates
      fill_interleave();
      bmem[7]  = 8'h40;
      bmem[15] = 8'h40;
      load_cnt(32);
      push_buf(32, "dup");
      look(8'h40, "R9 duplicate lowest");
      chk("R9 lowest slot", int'(lk_slot), 3);

      // R6 illegal counts
      load_cnt(0);
      push_buf(0, "cnt0");
      look(8'h00, "R6 cnt0 lookup");
      @(negedge clk);
      chk("R6 error holds", int'(cnt_err), 1);
      load_cnt(33);
      push_buf(33, "cnt33");
      look(8'h01, "R6 cnt33 lookup");

      // R11 restart clears errors and table
      load_cnt(32);
      push_buf(32, "restore");
      buf_start = 1'b1;
      @(negedge clk);
      buf_start = 1'b0;
      chk("R11 cnt_err cleared", int'(cnt_err), 0);
      mcnt = 0;
      look(bmem[1], "R11 table inactive");

      // random tables
      for (int r = 0; r < 20; r++) begin
         int c;
         c = 1 + int'($urandom % MAXS);
         for (int i = 0; i < MAXS; i++) begin
            int sel;
            sel = int'($urandom % 16);
            if (sel < 4)       bmem[2*i] = 8'h80;
            else if (sel == 4) bmem[2*i] = 8'h01 + 8'($urandom % 127);
            else               bmem[2*i] = 8'h00;
            bmem[2*i+1] = 8'($urandom % 40);
         end
         for (int i = 2 * MAXS; i < BUF; i++) bmem[i] = 8'($urandom);
         load_cnt(c);
         push_buf(c, "rand");
         for (int k = 0; k < 30; k++) look(8'($urandom % 48), "rand");
      end

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
      end
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
      end
      $finish;
   end

endmodule